// File: doc/BRIEF.md
# Page Replacement Policy Engine

This block models a small pool of physical page frames fed by a stream of page-number references, one for each cycle in which the reference strobe is high. For every reference it decides whether the page is already resident (a hit) or missing (a fault). On a fault it picks the frame that takes the new page. That frame is either a free one or the one that loses its page under the replacement policy chosen at run time.

The policy select can change between references. The engine always keeps both the load order and the use order of the frames, and a use counter for each frame, so every policy sees correct history whichever policy came before it. A running fault total is available at all times. With it, a known reference string can be replayed to get an exact fault figure for each policy.

Top module: `page_repl_engine`

## Requirements
- R1: A synchronous reset marks every frame empty, clears the fault total to zero and drives `hit`, `fault` and `evict` low.
- R2: When `ref_valid` is high on a clock edge, exactly one of `hit` and `fault` is high in the following cycle. When `ref_valid` was low, both are low.
- R3: A fault that finds an empty frame fills the lowest-indexed empty frame, reports that index on `frame_idx`, and keeps `evict` low. A fault with no empty frame raises `evict`.
- R4: Policy code 2'b00 (first-in first-out) evicts the page that was loaded earliest. Hits do not change this order.
- R5: Policy code 2'b01 (least recently used) evicts the page whose last reference is oldest. A hit makes that page the newest.
- R6: Policy code 2'b10 (least frequently used) evicts the page with the smallest use count. The lowest frame index wins a tie. A page's count is set to 1 when it is loaded, rises by 1 on each hit, and saturates at its maximum of 2^RCNT_W-1.
- R7: Policy code 2'b11 (most frequently used) evicts the page with the largest use count. The lowest frame index wins a tie.
- R8: `fault_count` rises by one for each fault and holds at all ones instead of wrapping.
- R9: With three frames, the string 7 0 1 2 0 3 0 4 2 3 0 3 2 1 2 0 1 7 0 1 yields 15 faults under policy 2'b00 and 12 faults under policy 2'b01.
- R10: A cycle with `ref_valid` low changes no frame contents, order, use count or fault total.
- R11: On a hit, `frame_idx` gives the index of the frame that holds the referenced page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_page | input | PAGE_W | Referenced page number |
| policy | input | 2 | Replacement policy code |
| hit | output | 1 | Previous reference was resident |
| fault | output | 1 | Previous reference was missing |
| evict | output | 1 | Previous fault displaced a resident page |
| frame_idx | output | IDX_W | Frame that was hit or filled |
| fault_count | output | FCNT_W | Saturating fault total |

## Verification
The assertions check on every cycle that hit and fault are mutually exclusive and appear only after a reference, that every reference produces an outcome, that an eviction is always part of a fault, and that the fault total steps by one or holds. Which frame is chosen, under each of the four policies, can only be shown by the bench scenarios. The bench replays the textbook string and pseudo-random strings through an independent timestamp-based model and compares frame choices, use-count saturation, idle cycles and the fault total at every reference.

// File: rtl/page_repl_engine.sv
module page_repl_engine #(
  parameter int NFRAMES = 3,
  parameter int PAGE_W  = 8,
  parameter int RCNT_W  = 4,
  parameter int FCNT_W  = 16,
  localparam int IDX_W  = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_valid,
  input  logic [PAGE_W-1:0] ref_page,
  input  logic [1:0]        policy,
  output logic              hit,
  output logic              fault,
  output logic              evict,
  output logic [IDX_W-1:0]  frame_idx,
  output logic [FCNT_W-1:0] fault_count
);
  localparam logic [1:0] POL_FIFO = 2'b00;
  localparam logic [1:0] POL_LRU  = 2'b01;
  localparam logic [1:0] POL_LFU  = 2'b10;

  logic [NFRAMES-1:0]             vld;
  logic [NFRAMES-1:0][PAGE_W-1:0] pg;
  logic [NFRAMES-1:0][IDX_W-1:0]  load_age;
  logic [NFRAMES-1:0][IDX_W-1:0]  use_age;
  logic [NFRAMES-1:0][RCNT_W-1:0] rcnt;

  logic             hit_any, free_any;
  logic [IDX_W-1:0] hit_i, free_i, vic_i, tgt;

  always_comb begin
    hit_any  = 1'b0;
    hit_i    = '0;
    free_any = 1'b0;
    free_i   = '0;
    vic_i    = '0;
    for (int i = 0; i < NFRAMES; i++) begin
      if (vld[i] && pg[i] == ref_page && !hit_any) begin
        hit_any = 1'b1;
        hit_i   = IDX_W'(i);
      end
      if (!vld[i] && !free_any) begin
        free_any = 1'b1;
        free_i   = IDX_W'(i);
      end
    end
    for (int i = 1; i < NFRAMES; i++) begin
      case (policy)
        POL_FIFO: if (load_age[i] > load_age[vic_i]) vic_i = IDX_W'(i);
        POL_LRU:  if (use_age[i]  > use_age[vic_i])  vic_i = IDX_W'(i);
        POL_LFU:  if (rcnt[i]     < rcnt[vic_i])     vic_i = IDX_W'(i);
        default:  if (rcnt[i]     > rcnt[vic_i])     vic_i = IDX_W'(i);
      endcase
    end
  end

  assign tgt = hit_any ? hit_i : (free_any ? free_i : vic_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld         <= '0;
      pg          <= '0;
      load_age    <= '0;
      use_age     <= '0;
      rcnt        <= '0;
      hit         <= 1'b0;
      fault       <= 1'b0;
      evict       <= 1'b0;
      frame_idx   <= '0;
      fault_count <= '0;
    end else begin
      hit   <= ref_valid && hit_any;
      fault <= ref_valid && !hit_any;
      evict <= ref_valid && !hit_any && !free_any;
      if (ref_valid) begin
        frame_idx <= tgt;
        if (!hit_any && fault_count != '1) fault_count <= fault_count + 1'b1;
        for (int i = 0; i < NFRAMES; i++) begin
          if (IDX_W'(i) == tgt) begin
            use_age[i] <= '0;
            if (!hit_any) begin
              vld[i]      <= 1'b1;
              pg[i]       <= ref_page;
              load_age[i] <= '0;
              rcnt[i]     <= RCNT_W'(1);
            end else if (rcnt[i] != '1) begin
              rcnt[i] <= rcnt[i] + 1'b1;
            end
          end else if (vld[i]) begin
            if (!vld[tgt] || use_age[i] < use_age[tgt])
              use_age[i] <= use_age[i] + 1'b1;
            if (!hit_any && (!vld[tgt] || load_age[i] < load_age[tgt]))
              load_age[i] <= load_age[i] + 1'b1;
          end
        end
      end
    end
  end
endmodule

module page_repl_engine_chk #(
  parameter int FCNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_valid,
  input logic              hit,
  input logic              fault,
  input logic              evict,
  input logic [FCNT_W-1:0] fault_count
);
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst) !(hit && fault));
  a_r2_needs_ref: assert property (@(posedge clk) disable iff (rst)
    (hit || fault) |-> $past(ref_valid));
  a_r2_ref_answered: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> (hit || fault));
  a_r3_evict_is_fault: assert property (@(posedge clk) disable iff (rst) evict |-> fault);
  a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
    (fault && $past(fault_count) != {FCNT_W{1'b1}}) |-> fault_count == $past(fault_count) + 1'b1);
  a_r8_count_hold: assert property (@(posedge clk) disable iff (rst)
    !fault |-> $stable(fault_count));
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
    $past(fault_count) == {FCNT_W{1'b1}} |-> fault_count == {FCNT_W{1'b1}});
endmodule

bind page_repl_engine page_repl_engine_chk #(.FCNT_W(FCNT_W)) u_chk (
  .clk(clk), .rst(rst), .ref_valid(ref_valid), .hit(hit), .fault(fault),
  .evict(evict), .fault_count(fault_count)
);

// File: tb/tb_page_repl_engine.sv
module tb_page_repl_engine;
  localparam int N  = 3;
  localparam int PW = 8;
  localparam int RW = 4;
  localparam int FW = 5;
  localparam int IW = 2;

  logic clk = 1'b0, rst = 1'b1, ref_valid = 1'b0;
  logic [PW-1:0] ref_page = '0;
  logic [1:0] policy = 2'b00;
  logic hit, fault, evict;
  logic [IW-1:0] frame_idx;
  logic [FW-1:0] fault_count;

  int checks = 0, failures = 0;

  int m_vld[N], m_page[N], m_load[N], m_use[N], m_cnt[N];
  int m_time, m_faults;

  page_repl_engine #(.NFRAMES(N), .PAGE_W(PW), .RCNT_W(RW), .FCNT_W(FW)) dut (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_page(ref_page), .policy(policy),
    .hit(hit), .fault(fault), .evict(evict), .frame_idx(frame_idx), .fault_count(fault_count));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_page[i] = 0; m_load[i] = 0; m_use[i] = 0; m_cnt[i] = 0;
    end
    m_time = 0; m_faults = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ref_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  task automatic do_ref(input int pol, input int p);
    int hi, fr, v;
    bit eh, ev;
    string rq;
    rq = (pol == 0) ? "R4" : (pol == 1) ? "R5" : (pol == 2) ? "R6" : "R7";
    hi = -1; fr = -1;
    for (int i = 0; i < N; i++) if (m_vld[i] != 0 && m_page[i] == p && hi < 0) hi = i;
    for (int i = 0; i < N; i++) if (m_vld[i] == 0 && fr < 0) fr = i;
    m_time++;
    eh = (hi >= 0); ev = 0;
    if (eh) begin
      v = hi;
      m_use[v] = m_time;
      if (m_cnt[v] < (1 << RW) - 1) m_cnt[v]++;
    end else begin
      if (fr >= 0) v = fr;
      else begin
        ev = 1; v = 0;
        for (int i = 1; i < N; i++) begin
          case (pol)
            0: if (m_load[i] < m_load[v]) v = i;
            1: if (m_use[i] < m_use[v]) v = i;
            2: if (m_cnt[i] < m_cnt[v]) v = i;
            default: if (m_cnt[i] > m_cnt[v]) v = i;
          endcase
        end
      end
      m_vld[v] = 1; m_page[v] = p; m_load[v] = m_time; m_use[v] = m_time; m_cnt[v] = 1;
      if (m_faults < (1 << FW) - 1) m_faults++;
    end
    ref_valid = 1'b1; ref_page = PW'(p); policy = 2'(pol);
    @(posedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
    check(hit == eh && fault == !eh, "R2 outcome", {hit, fault}, {eh, !eh});
    check(evict == ev, ev ? rq : "R3 evict", evict, ev);
    check(int'(frame_idx) == v, eh ? "R11 hit frame" : (ev ? rq : "R3 fill frame"), frame_idx, v);
    check(int'(fault_count) == m_faults, "R8 fault total", fault_count, m_faults);
  endtask

  int str[20] = '{7,0,1,2,0,3,0,4,2,3,0,3,2,1,2,0,1,7,0,1};

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lf;
    do_reset();
    @(negedge clk);
    check(fault_count == 0 && !hit && !fault && !evict, "R1 reset state", fault_count, 0);

    for (int pol = 0; pol < 4; pol++) begin
      do_reset();
      for (int k = 0; k < 20; k++) do_ref(pol, str[k]);
      if (pol == 0) check(fault_count == 15, "R9 FIFO total", fault_count, 15);
      if (pol == 1) check(fault_count == 12, "R9 LRU total", fault_count, 12);
    end

    // R10: idle cycles carry a page that would otherwise fault
    do_reset();
    do_ref(1, 1); do_ref(1, 2); do_ref(1, 3);
    ref_valid = 1'b0; ref_page = 8'd9;
    repeat (3) begin
      @(negedge clk);
      check(!hit && !fault && fault_count == 3, "R10 idle", {hit, fault, fault_count}, 3);
    end
    do_ref(1, 1);
    check(hit && frame_idx == 0, "R10 state kept", hit, 1);
    do_ref(1, 9);
    check(frame_idx == 1, "R10 LRU order kept", frame_idx, 1);

    // R6: use count saturation, then least and most used choices
    do_reset();
    do_ref(2, 1); do_ref(2, 2); do_ref(2, 3);
    for (int k = 0; k < 20; k++) do_ref(2, 1);
    do_ref(2, 3);
    do_ref(2, 4);
    check(frame_idx == 1, "R6 least used evicted", frame_idx, 1);
    do_ref(3, 5);
    check(frame_idx == 0, "R7 most used evicted", frame_idx, 0);

    // pseudo-random sweeps under every policy, saturating the fault total (R8)
    lf = 32'h1d5;
    for (int pol = 0; pol < 4; pol++) begin
      for (int s = 0; s < 4; s++) begin
        do_reset();
        for (int k = 0; k < 50; k++) begin
          lf = (lf >> 1) ^ ((lf & 1) ? 32'hb400 : 0);
          do_ref(pol, (lf & 7) % 6);
        end
      end
    end
    do_reset();
    for (int k = 0; k < 40; k++) do_ref(0, k);
    check(fault_count == 31, "R8 saturated", fault_count, 31);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule